// File: doc/BRIEF.md
# Shared-Clock Dual-Port Memory with Same-Address Collision Handling

This block is a synchronous memory with two symmetric ports, A and B. Both ports run on one clock. Each port has its own address, write strobe and write data, and each can read or write in any cycle. Read data is registered and shows up on the cycle after the address is applied.

A per-instance parameter sets what a port's read output shows in a cycle in which that port writes. In write-first mode it shows the new word. In read-first mode it shows the word that was stored before. In no-change mode it keeps its earlier value.

When both ports hit the same word in one cycle and at least one of them writes, a raw storage array gives no guaranteed result. With the bypass parameter set, steering logic around the array makes that result defined. A reading port receives the word being written by the other port. In a double write, port A's word is stored. Clearing the parameter removes that logic for systems that can never collide. A collision flag reports every same-address access that involves a write, whether or not the bypass is present.

Top module: `dual_port_mem`

## Requirements
- R1: A word written through either port is returned on a later read of that address by either port, with read data valid on the clock edge after the address is presented. The memory holds all zeros at the start of simulation.
- R2: In write-first mode (WR_MODE = WM_WRITE_FIRST), a writing port's read output on the next cycle equals the data it wrote.
- R3: In read-first mode (WR_MODE = WM_READ_FIRST), a writing port's read output on the next cycle equals the word that was stored at that address before the write.
- R4: In no-change mode (WR_MODE = WM_NO_CHANGE), a writing port's read output holds the value it had before the write cycle.
- R5: With BYPASS_EN = 1, a port that reads the address the other port writes in the same cycle returns the newly written word on the next cycle.
- R6: With BYPASS_EN = 1, when both ports write one address in the same cycle, port A's word is stored. In write-first mode, both ports return port A's word.
- R7: coll_o is high for exactly the cycle after a cycle with a_addr_i == b_addr_i and at least one write strobe set. It is low otherwise, for either value of BYPASS_EN.
- R8: With BYPASS_EN = 0, accesses that do not collide behave exactly as in R1 to R4.
- R9: While rst_ni is low, both read outputs and coll_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the output registers |
| a_addr_i | input | ADDR_W = log2(DEPTH) | Port A word address |
| a_we_i | input | 1 | Port A write strobe |
| a_wdata_i | input | DATA_W | Port A write data |
| a_rdata_o | output | DATA_W | Port A registered read data |
| b_addr_i | input | ADDR_W | Port B word address |
| b_we_i | input | 1 | Port B write strobe |
| b_wdata_i | input | DATA_W | Port B write data |
| b_rdata_o | output | DATA_W | Port B registered read data |
| coll_o | output | 1 | Same-address access with a write detected in the previous cycle |

## Verification
The bench sweeps every address pair and every combination of the two write strobes on a 16-word memory. It drives three instances side by side: write-first with bypass, read-first with bypass, and no-change without bypass. A missing bypass would let a reading port return stale data when the other port writes its address. A wrong write priority would leave port B's word in place after a double write. A wrong mode decode would show new data where old or held data is expected. The collision flag is compared on every cycle, which catches a flag that fires for two reads or only when the bypass is present. For the bypass-free instance, the bench does not check outcomes that are truly undefined. It tracks which words a double write has made unknown and checks only accesses that do not collide.

// File: rtl/dpm_pkg.sv
`timescale 1ns/1ps
package dpm_pkg;
  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wr_mode_e;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_HOLD   = 2'd2
  } out_src_e;
endpackage

// File: rtl/dpm_array.sv
`timescale 1ns/1ps
module dpm_array #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic              a_we_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic              b_we_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] a_raw_o,
  output logic [DATA_W-1:0] b_raw_o
);
  // zero fill applies to simulation only; no hardware reset of storage
  logic [DATA_W-1:0] mem_q [DEPTH] = '{default: '0};

  always_ff @(posedge clk_i) begin
    if (b_we_i) mem_q[b_addr_i] <= b_wdata_i;
    if (a_we_i) mem_q[a_addr_i] <= a_wdata_i; // later update: A wins a double write
    a_raw_o <= mem_q[a_addr_i];
    b_raw_o <= mem_q[b_addr_i];
  end
endmodule

// File: rtl/dpm_coll_det.sv
`timescale 1ns/1ps
module dpm_coll_det #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic              b_we_i,
  output logic              same_addr_o,
  output logic              coll_o
);
  assign same_addr_o = (a_addr_i == b_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coll_o <= 1'b0;
    else         coll_o <= same_addr_o && (a_we_i || b_we_i);
  end
endmodule

// File: rtl/dpm_port_out.sv
`timescale 1ns/1ps
module dpm_port_out
  import dpm_pkg::*;
#(
  parameter int       DATA_W    = 16,
  parameter wr_mode_e WR_MODE   = WM_WRITE_FIRST,
  parameter bit       BYPASS_EN = 1'b1,
  parameter bit       IS_B      = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              own_we_i,
  input  logic              oth_we_i,
  input  logic              same_addr_i,
  input  logic [DATA_W-1:0] own_wdata_i,
  input  logic [DATA_W-1:0] oth_wdata_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] rdata_o
);
  out_src_e          src_d, src_q;
  logic [DATA_W-1:0] byp_d, byp_q, hold_q;
  logic              hit;

  assign hit = same_addr_i && oth_we_i;

  always_comb begin
    src_d = SRC_ARRAY;
    byp_d = own_wdata_i;
    if (!own_we_i) begin
      if (BYPASS_EN && hit) begin
        src_d = SRC_BYPASS;
        byp_d = oth_wdata_i;
      end
    end else begin
      case (WR_MODE)
        WM_WRITE_FIRST: begin
          src_d = SRC_BYPASS;
          if (BYPASS_EN && IS_B && hit) byp_d = oth_wdata_i; // B shows A's stored word
        end
        WM_READ_FIRST: src_d = SRC_ARRAY;
        default:       src_d = SRC_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= SRC_BYPASS;
      byp_q  <= '0;
      hold_q <= '0;
    end else begin
      src_q  <= src_d;
      byp_q  <= byp_d;
      hold_q <= rdata_o;
    end
  end

  always_comb begin
    case (src_q)
      SRC_BYPASS: rdata_o = byp_q;
      SRC_HOLD:   rdata_o = hold_q;
      default:    rdata_o = raw_i;
    endcase
  end
endmodule

// File: rtl/dual_port_mem.sv
`timescale 1ns/1ps
module dual_port_mem
  import dpm_pkg::*;
#(
  parameter int       DATA_W    = 16,
  parameter int       DEPTH     = 256,
  parameter wr_mode_e WR_MODE   = WM_WRITE_FIRST,
  parameter bit       BYPASS_EN = 1'b1,
  localparam int      ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic              a_we_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic              b_we_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              coll_o
);
  localparam int NPORT = 2;

  logic              same_addr;
  logic              we    [NPORT];
  logic [DATA_W-1:0] wdata [NPORT];
  logic [DATA_W-1:0] raw   [NPORT];
  logic [DATA_W-1:0] rdata [NPORT];

  assign we[0]    = a_we_i;
  assign we[1]    = b_we_i;
  assign wdata[0] = a_wdata_i;
  assign wdata[1] = b_wdata_i;
  assign a_rdata_o = rdata[0];
  assign b_rdata_o = rdata[1];

  dpm_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
    .clk_i     (clk_i),
    .a_addr_i  (a_addr_i),
    .a_we_i    (a_we_i),
    .a_wdata_i (a_wdata_i),
    .b_addr_i  (b_addr_i),
    .b_we_i    (b_we_i),
    .b_wdata_i (b_wdata_i),
    .a_raw_o   (raw[0]),
    .b_raw_o   (raw[1])
  );

  dpm_coll_det #(.ADDR_W(ADDR_W)) u_coll (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .a_addr_i    (a_addr_i),
    .a_we_i      (a_we_i),
    .b_addr_i    (b_addr_i),
    .b_we_i      (b_we_i),
    .same_addr_o (same_addr),
    .coll_o      (coll_o)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpm_port_out #(
      .DATA_W    (DATA_W),
      .WR_MODE   (WR_MODE),
      .BYPASS_EN (BYPASS_EN),
      .IS_B      (p == 1)
    ) u_out (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .own_we_i    (we[p]),
      .oth_we_i    (we[NPORT-1-p]),
      .same_addr_i (same_addr),
      .own_wdata_i (wdata[p]),
      .oth_wdata_i (wdata[NPORT-1-p]),
      .raw_i       (raw[p]),
      .rdata_o     (rdata[p])
    );
  end
endmodule

// File: rtl/dpm_chk.sv
`timescale 1ns/1ps
module dpm_chk
  import dpm_pkg::*;
#(
  parameter int       DATA_W    = 16,
  parameter int       DEPTH     = 256,
  parameter wr_mode_e WR_MODE   = WM_WRITE_FIRST,
  parameter bit       BYPASS_EN = 1'b1,
  localparam int      ADDR_W    = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] a_addr_i,
  input logic              a_we_i,
  input logic [DATA_W-1:0] a_wdata_i,
  input logic [DATA_W-1:0] a_rdata_o,
  input logic [ADDR_W-1:0] b_addr_i,
  input logic              b_we_i,
  input logic [DATA_W-1:0] b_wdata_i,
  input logic [DATA_W-1:0] b_rdata_o,
  input logic              coll_o
);
  logic same;
  assign same = (a_addr_i == b_addr_i);

  p_coll_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    same && (a_we_i || b_we_i) |=> coll_o);
  p_coll_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(same && (a_we_i || b_we_i)) |=> !coll_o);

  p_reset_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (a_rdata_o == '0) && (b_rdata_o == '0) && !coll_o);

  if (BYPASS_EN) begin : g_byp
    p_bypass_ab_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_we_i && !b_we_i && same |=> b_rdata_o == $past(a_wdata_i));
    p_bypass_ba_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      b_we_i && !a_we_i && same |=> a_rdata_o == $past(b_wdata_i));
  end

  if (WR_MODE == WM_WRITE_FIRST) begin : g_wf
    p_wf_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_we_i |=> a_rdata_o == $past(a_wdata_i));
    if (BYPASS_EN) begin : g_dbl
      p_dbl_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        a_we_i && b_we_i && same |=> b_rdata_o == $past(a_wdata_i));
    end
  end

  if (WR_MODE == WM_NO_CHANGE) begin : g_nc
    p_nc_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_we_i |=> a_rdata_o == $past(a_rdata_o));
    p_nc_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      b_we_i |=> b_rdata_o == $past(b_rdata_o));
  end
endmodule

bind dual_port_mem dpm_chk #(
  .DATA_W    (DATA_W),
  .DEPTH     (DEPTH),
  .WR_MODE   (WR_MODE),
  .BYPASS_EN (BYPASS_EN)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .a_addr_i  (a_addr_i),
  .a_we_i    (a_we_i),
  .a_wdata_i (a_wdata_i),
  .a_rdata_o (a_rdata_o),
  .b_addr_i  (b_addr_i),
  .b_we_i    (b_we_i),
  .b_wdata_i (b_wdata_i),
  .b_rdata_o (b_rdata_o),
  .coll_o    (coll_o)
);

// File: tb/sim_dual_port_mem.sv
`timescale 1ns/1ps
module sim_dual_port_mem;
  import dpm_pkg::*;

  localparam int DW  = 8;
  localparam int DEP = 16;
  localparam int AW  = 4;
  localparam int NI  = 3;

  // instance 0: write-first+bypass, 1: read-first+bypass, 2: no-change, no bypass
  localparam int MODE [NI] = '{0, 1, 2};
  localparam bit BYP  [NI] = '{1'b1, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic a_we = 1'b0, b_we = 1'b0;
  logic [DW-1:0] a_wd = '0, b_wd = '0;
  logic [DW-1:0] rd [NI][2];
  logic coll [NI];

  always #5 clk = ~clk;

  dual_port_mem #(.DATA_W(DW), .DEPTH(DEP), .WR_MODE(WM_WRITE_FIRST), .BYPASS_EN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_addr_i(a_addr), .a_we_i(a_we), .a_wdata_i(a_wd), .a_rdata_o(rd[0][0]),
    .b_addr_i(b_addr), .b_we_i(b_we), .b_wdata_i(b_wd), .b_rdata_o(rd[0][1]),
    .coll_o(coll[0]));
  dual_port_mem #(.DATA_W(DW), .DEPTH(DEP), .WR_MODE(WM_READ_FIRST), .BYPASS_EN(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_addr_i(a_addr), .a_we_i(a_we), .a_wdata_i(a_wd), .a_rdata_o(rd[1][0]),
    .b_addr_i(b_addr), .b_we_i(b_we), .b_wdata_i(b_wd), .b_rdata_o(rd[1][1]),
    .coll_o(coll[1]));
  dual_port_mem #(.DATA_W(DW), .DEPTH(DEP), .WR_MODE(WM_NO_CHANGE), .BYPASS_EN(1'b0)) u2 (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_addr_i(a_addr), .a_we_i(a_we), .a_wdata_i(a_wd), .a_rdata_o(rd[2][0]),
    .b_addr_i(b_addr), .b_we_i(b_we), .b_wdata_i(b_wd), .b_rdata_o(rd[2][1]),
    .coll_o(coll[2]));

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] mdl [DEP];
  bit            unk [DEP];
  logic [DW-1:0] prev [NI][2];
  bit            pv   [NI][2];
  string         tag_ovr = "";

  task automatic check(input string tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic predict(input int inst, input bit isb, input bit w, input bit ow,
                         input bit eq, input logic [DW-1:0] own_d,
                         input logic [DW-1:0] oth_d, input logic [DW-1:0] old,
                         input bit old_ok, output logic [DW-1:0] v, output bit ok,
                         output string tag);
    v = old; ok = old_ok; tag = BYP[inst] ? "R1" : "R8";
    if (!w) begin
      if (eq && ow) begin
        tag = "R5";
        if (BYP[inst]) begin v = oth_d; ok = 1'b1; end
        else ok = 1'b0;
      end
    end else if (MODE[inst] == 0) begin
      tag = "R2"; v = own_d; ok = 1'b1;
      if (eq && ow) begin
        tag = "R6";
        if (BYP[inst] && isb) v = oth_d;
        else if (!BYP[inst]) ok = 1'b0;
      end
    end else if (MODE[inst] == 1) begin
      tag = "R3";
    end else begin
      tag = "R4"; v = prev[inst][isb]; ok = pv[inst][isb];
    end
    if (tag_ovr != "") tag = tag_ovr;
  endtask

  task automatic step(input int aa, input bit awe, input logic [DW-1:0] ad,
                      input int ba, input bit bwe, input logic [DW-1:0] bd);
    logic [DW-1:0] ev [NI][2];
    bit            eok [NI][2];
    string         etag [NI][2];
    bit            eq;
    a_addr = AW'(aa); a_we = awe; a_wd = ad;
    b_addr = AW'(ba); b_we = bwe; b_wd = bd;
    eq = (aa == ba);
    for (int i = 0; i < NI; i++) begin
      predict(i, 1'b0, awe, bwe, eq, ad, bd, mdl[aa], BYP[i] || !unk[aa],
              ev[i][0], eok[i][0], etag[i][0]);
      predict(i, 1'b1, bwe, awe, eq, bd, ad, mdl[ba], BYP[i] || !unk[ba],
              ev[i][1], eok[i][1], etag[i][1]);
      for (int p = 0; p < 2; p++) begin
        prev[i][p] = ev[i][p];
        pv[i][p]   = eok[i][p];
      end
    end
    if (awe && bwe && eq) begin
      mdl[aa] = ad; unk[aa] = 1'b1;
    end else begin
      if (bwe) begin mdl[ba] = bd; unk[ba] = 1'b0; end
      if (awe) begin mdl[aa] = ad; unk[aa] = 1'b0; end
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < NI; i++) begin
      check("R7", $sformatf("u%0d coll", i), {7'd0, coll[i]},
            {7'd0, eq && (awe || bwe)});
      for (int p = 0; p < 2; p++)
        if (eok[i][p])
          check(etag[i][p], $sformatf("u%0d port%0d rdata", i, p), rd[i][p], ev[i][p]);
    end
  endtask

  initial begin
    for (int k = 0; k < DEP; k++) begin mdl[k] = '0; unk[k] = 1'b0; end
    for (int i = 0; i < NI; i++)
      for (int p = 0; p < 2; p++) begin prev[i][p] = '0; pv[i][p] = 1'b1; end
    a_we = 1'b1; a_wd = 8'hFF; // write strobe during reset must not disturb outputs
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < NI; i++) begin
      check("R9", $sformatf("u%0d reset a", i), rd[i][0], '0);
      check("R9", $sformatf("u%0d reset b", i), rd[i][1], '0);
      check("R9", $sformatf("u%0d reset coll", i), {7'd0, coll[i]}, '0);
    end
    mdl[0] = 8'hFF; // array keeps taking writes while outputs are in reset
    a_we = 1'b0;
    rst_ni = 1'b1;
    // initial contents are zero
    for (int a = 1; a < DEP; a++) step(a, 1'b0, '0, DEP - a, 1'b0, '0);
    // fill through port A while B reads the next word
    for (int a = 0; a < DEP; a++) step(a, 1'b1, 8'(a * 7 + 3), (a + 1) % DEP, 1'b0, '0);
    // all address pairs, all strobe combinations
    for (int a = 0; a < DEP; a++)
      for (int b = 0; b < DEP; b++)
        for (int c = 0; c < 4; c++)
          step(a, c[0], 8'(a * 16 + b + c * 53), b, c[1], 8'(~(a * 16 + b) + c));
    // directed double write, A must win
    step(5, 1'b1, 8'hA5, 5, 1'b1, 8'h5A);
    tag_ovr = "R6";
    step(5, 1'b0, '0, 5, 1'b0, '0);
    tag_ovr = "";
    // read everything back
    for (int a = 0; a < DEP; a++) step(a, 1'b0, '0, DEP - 1 - a, 1'b0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule